// File: doc/BRIEF.md
# Return Address Stack Predictor

This block keeps a short last-in/first-out copy of the return addresses written by recent subroutine calls. When a subroutine return is decoded, the newest copy is removed and offered straight away as a speculative fetch address. Instruction fetch can then start on the likely return target while the real return address is still being read from the memory-based system stack.

When the real address comes back, the block compares it with the guess it made. If they differ, it raises a one-cycle cancel and gives the real address as the redirect target. If they agree, fetch carries on undisturbed. Interrupt and trap entries, and the matching return-from-interrupt, go around the predictor. A wrong guess does not repair the remaining copies. So once software has rewritten stacked return addresses, the older copies stay misaligned and keep producing wrong guesses until they are used up.

Each address has an 8-bit code-segment part and a 16-bit offset part. For an inter-segment return, the guess uses the saved segment. For an intra-segment return, the guess uses the segment currently executing, joined to the saved offset.

Top module: `ret_addr_predictor`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) empties the store, so the first return after reset gives predict_valid low.
- R2: An event with evt_kind 3'd1 (call) pushes {call_seg, call_off}. Returns remove entries newest first.
- R3: A return with evt_kind 3'd4 (inter-segment) on a non-empty store sets predict_valid high in the same cycle, with predict_seg:predict_off equal to the saved segment and saved offset.
- R4: A return with evt_kind 3'd3 (intra-segment) on a non-empty store sets predict_valid high in the same cycle, with predict_seg equal to cur_seg and predict_off equal to the saved offset.
- R5: An event with evt_kind 3'd2 (interrupt or trap entry) stores nothing.
- R6: An event with evt_kind 3'd5 (return from interrupt) gives predict_valid low and removes nothing.
- R7: When act_valid arrives after a predicted return and act_seg:act_off equals the prediction, cancel and redirect_valid stay low.
- R8: When the actual address differs from the prediction, cancel and redirect_valid are both high in that cycle, and redirect_seg:redirect_off equals the actual address.
- R9: A wrong guess leaves the remaining entries unchanged. The next return still predicts the next stale entry.
- R10: The store holds 6 entries. A call made while it is full drops the oldest entry and keeps the newest 6.
- R11: A return on an empty store gives predict_valid low. Its actual address is then passed to redirect with redirect_valid high and cancel low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | An event is present this cycle |
| evt_kind | input | 3 | 1 call, 2 trap/interrupt entry, 3 intra-segment return, 4 inter-segment return, 5 interrupt return; other values are no-ops |
| call_seg | input | 8 | Segment part of the call's return address |
| call_off | input | 16 | Offset part of the call's return address |
| cur_seg | input | 8 | Code segment currently executing |
| act_valid | input | 1 | Actual return address from the system stack is present |
| act_seg | input | 8 | Actual return segment |
| act_off | input | 16 | Actual return offset |
| predict_valid | output | 1 | Speculative fetch address is valid |
| predict_seg | output | 8 | Speculative fetch segment |
| predict_off | output | 16 | Speculative fetch offset |
| cancel | output | 1 | Discard the speculatively fetched instruction |
| redirect_valid | output | 1 | Fetch must restart at the redirect address |
| redirect_seg | output | 8 | Redirect segment |
| redirect_off | output | 16 | Redirect offset |

## Verification
The bench uses the default depth of 6, with an 8-bit segment and a 16-bit offset. Seven calls are therefore enough to reach the overflow that drops the oldest entry, and a seventh return then reaches the empty-store pass-through. Because the segment is narrow, intra-segment and inter-segment returns with different current segments can be told apart directly. A bench-side model rewrites stacked addresses to reproduce the run of stale mismatches that follows.

// File: rtl/rap_pkg.sv
package rap_pkg;
  parameter int RAP_SEG_W = 8;
  parameter int RAP_OFF_W = 16;
  localparam int RAP_ADDR_W = RAP_SEG_W + RAP_OFF_W;

  typedef struct packed {
    logic [RAP_SEG_W-1:0] seg;
    logic [RAP_OFF_W-1:0] off;
  } rap_addr_t;

  typedef enum logic [2:0] {
    EV_IDLE     = 3'd0,
    EV_CALL     = 3'd1,
    EV_TRAP     = 3'd2,
    EV_RET_NEAR = 3'd3,
    EV_RET_FAR  = 3'd4,
    EV_RETI     = 3'd5
  } rap_evt_e;

  // Predicted target: a far return keeps the saved segment, a near one the current segment.
  function automatic rap_addr_t rap_target(input logic far_ret,
                                           input logic [RAP_SEG_W-1:0] cur_seg,
                                           input rap_addr_t saved);
    rap_addr_t t;
    t.off = saved.off;
    t.seg = far_ret ? saved.seg : cur_seg;
    return t;
  endfunction

  function automatic logic rap_differs(input rap_addr_t a, input rap_addr_t b);
    return (a.seg != b.seg) || (a.off != b.off);
  endfunction
endpackage

// File: rtl/rap_event_decode.sv
module rap_event_decode (
  input  logic       evt_valid,
  input  logic [2:0] evt_kind,
  output logic       push,
  output logic       pop,
  output logic       far_ret,
  output logic       trap_seen,
  output logic       reti_seen
);
  import rap_pkg::*;

  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    far_ret   = 1'b0;
    trap_seen = 1'b0;
    reti_seen = 1'b0;
    if (evt_valid) begin
      case (evt_kind)
        EV_CALL:     push = 1'b1;
        EV_TRAP:     trap_seen = 1'b1;
        EV_RET_NEAR: pop = 1'b1;
        EV_RET_FAR:  begin pop = 1'b1; far_ret = 1'b1; end
        EV_RETI:     reti_seen = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/rap_stack.sv
module rap_stack #(
  parameter int DEPTH = 6,
  parameter int W     = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     top,
  output logic             empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0] ent [DEPTH];
  logic         pop_eff;

  assign empty   = (count == '0);
  assign pop_eff = pop && !empty;
  assign top     = ent[0];

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic p, input logic q);
    if (p)      return (c == FULL) ? c : c + 1'b1;
    else if (q) return c - 1'b1;
    else        return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= next_count(count, push, pop_eff);
  end

  // Slot 0 is newest; a push shifts toward the far end, dropping the oldest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] above, below;
    if (i == 0) begin : g_first
      assign above = din;
    end else begin : g_mid_a
      assign above = ent[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign below = '0;
    end else begin : g_mid_b
      assign below = ent[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)          ent[i] <= '0;
      else if (push)    ent[i] <= above;
      else if (pop_eff) ent[i] <= below;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  assert_full_push_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (push && count == FULL) |=> count == FULL);
  assert_pop_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count != '0) |=> count == $past(count) - 1'b1);
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> count == '0);
endmodule

// File: rtl/rap_verify.sv
module rap_verify
  import rap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ret_fire,
  input  logic      pred_valid,
  input  rap_addr_t pred_addr,
  input  logic      act_valid,
  input  rap_addr_t act_addr,
  output logic      cancel,
  output logic      redirect_valid,
  output rap_addr_t redirect_addr,
  output logic      pend_valid
);
  logic      pend_pred;
  rap_addr_t pend_addr;
  logic      check_now, wrong;

  assign check_now      = act_valid && pend_valid;
  assign wrong          = rap_differs(pend_addr, act_addr);
  assign cancel         = check_now && pend_pred && wrong;
  assign redirect_valid = check_now && (!pend_pred || wrong);
  assign redirect_addr  = act_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_pred  <= 1'b0;
      pend_addr  <= '0;
    end else if (ret_fire) begin
      pend_valid <= 1'b1;
      pend_pred  <= pred_valid;
      pend_addr  <= pred_addr;
    end else if (act_valid) begin
      pend_valid <= 1'b0;
    end
  end

  assert_cancel_redirects_R8: assert property (@(posedge clk) disable iff (rst)
    cancel |-> (redirect_valid && redirect_addr == act_addr));
  assert_actual_has_return_R7: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> pend_valid);
  assert_single_cycle_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !cancel);
endmodule

// File: rtl/ret_addr_predictor.sv
module ret_addr_predictor
  import rap_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_valid,
  input  logic [2:0]           evt_kind,
  input  logic [RAP_SEG_W-1:0] call_seg,
  input  logic [RAP_OFF_W-1:0] call_off,
  input  logic [RAP_SEG_W-1:0] cur_seg,
  input  logic                 act_valid,
  input  logic [RAP_SEG_W-1:0] act_seg,
  input  logic [RAP_OFF_W-1:0] act_off,
  output logic                 predict_valid,
  output logic [RAP_SEG_W-1:0] predict_seg,
  output logic [RAP_OFF_W-1:0] predict_off,
  output logic                 cancel,
  output logic                 redirect_valid,
  output logic [RAP_SEG_W-1:0] redirect_seg,
  output logic [RAP_OFF_W-1:0] redirect_off
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic push, pop, far_ret, trap_seen, reti_seen;
  logic empty, pend_valid;
  logic [CNT_W-1:0] count;
  logic [RAP_ADDR_W-1:0] top_raw;
  rap_addr_t top_addr, pred_addr, act_addr, redir_addr, call_addr;

  rap_event_decode u_dec (
    .evt_valid(evt_valid), .evt_kind(evt_kind), .push(push), .pop(pop),
    .far_ret(far_ret), .trap_seen(trap_seen), .reti_seen(reti_seen)
  );

  assign call_addr = '{seg: call_seg, off: call_off};

  rap_stack #(.DEPTH(DEPTH), .W(RAP_ADDR_W)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(call_addr),
    .top(top_raw), .empty(empty), .count(count)
  );

  assign top_addr      = rap_addr_t'(top_raw);
  assign predict_valid = pop && !empty;
  assign pred_addr     = rap_target(far_ret, cur_seg, top_addr);
  assign predict_seg   = pred_addr.seg;
  assign predict_off   = pred_addr.off;
  assign act_addr      = '{seg: act_seg, off: act_off};

  rap_verify u_ver (
    .clk(clk), .rst(rst), .ret_fire(pop), .pred_valid(predict_valid),
    .pred_addr(pred_addr), .act_valid(act_valid), .act_addr(act_addr),
    .cancel(cancel), .redirect_valid(redirect_valid),
    .redirect_addr(redir_addr), .pend_valid(pend_valid)
  );

  assign redirect_seg = redir_addr.seg;
  assign redirect_off = redir_addr.off;

  assert_trap_no_push_R5: assert property (@(posedge clk) disable iff (rst)
    trap_seen |=> count == $past(count));
  assert_reti_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
    reti_seen |=> count == $past(count));
  assert_reti_no_predict_R6: assert property (@(posedge clk) disable iff (rst)
    reti_seen |-> !predict_valid);
  assert_predict_needs_entry_R11: assert property (@(posedge clk) disable iff (rst)
    predict_valid |-> count != '0);
  assert_empty_no_cancel_R11: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> !cancel);
  assert_pending_set_R3: assert property (@(posedge clk) disable iff (rst)
    pop |=> pend_valid);
endmodule

// File: tb/ret_addr_predictor_test.sv
module ret_addr_predictor_test;
  logic clk = 1'b0;
  logic rst;
  logic evt_valid;
  logic [2:0] evt_kind;
  logic [7:0] call_seg, cur_seg, act_seg;
  logic [15:0] call_off, act_off;
  logic act_valid;
  logic predict_valid, cancel, redirect_valid;
  logic [7:0] predict_seg, redirect_seg;
  logic [15:0] predict_off, redirect_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] mstk [6];
  int mcnt = 0;
  logic        last_pv;
  logic [23:0] last_pa;

  always #5 clk = ~clk;

  ret_addr_predictor uut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .call_seg(call_seg), .call_off(call_off), .cur_seg(cur_seg),
    .act_valid(act_valid), .act_seg(act_seg), .act_off(act_off),
    .predict_valid(predict_valid), .predict_seg(predict_seg), .predict_off(predict_off),
    .cancel(cancel), .redirect_valid(redirect_valid),
    .redirect_seg(redirect_seg), .redirect_off(redirect_off)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); #1;
    evt_valid = 0; act_valid = 0; evt_kind = 3'd0;
  endtask

  task automatic model_push(input logic [23:0] a);
    for (int i = 5; i > 0; i--) mstk[i] = mstk[i-1];
    mstk[0] = a;
    if (mcnt < 6) mcnt++;
  endtask

  task automatic do_call(input logic [7:0] s, input logic [15:0] o);
    @(negedge clk);
    evt_valid = 1; evt_kind = 3'd1; call_seg = s; call_off = o;
    model_push({s, o});
    settle();
  endtask

  task automatic do_simple(input logic [2:0] k, input string req);
    @(negedge clk);
    evt_valid = 1; evt_kind = k;
    #1;
    chk(predict_valid == 0, req, {31'd0, predict_valid}, 0);
    settle();
  endtask

  // Return event, then the actual address one cycle later; checks both cycles.
  task automatic do_ret(input bit far, input logic [7:0] cs,
                        input logic [23:0] actual, input string req);
    logic [23:0] exp;
    bit exp_pv;
    @(negedge clk);
    evt_valid = 1; evt_kind = far ? 3'd4 : 3'd3; cur_seg = cs;
    exp_pv = (mcnt != 0);
    exp = far ? mstk[0] : {cs, mstk[0][15:0]};
    #1;
    chk(predict_valid == exp_pv, {req, " predict_valid"}, {31'd0, predict_valid}, {31'd0, exp_pv});
    if (exp_pv)
      chk({predict_seg, predict_off} == exp, {req, " predict addr"},
          {8'd0, predict_seg, predict_off}, {8'd0, exp});
    if (mcnt != 0) begin
      for (int i = 0; i < 5; i++) mstk[i] = mstk[i+1];
      mstk[5] = '0;
      mcnt--;
    end
    settle();
    @(negedge clk);
    act_valid = 1; {act_seg, act_off} = actual;
    #1;
    if (!exp_pv) begin
      chk(redirect_valid == 1 && cancel == 0, "R11 pass-through flags",
          {30'd0, redirect_valid, cancel}, 32'd2);
      chk({redirect_seg, redirect_off} == actual, "R11 pass-through addr",
          {8'd0, redirect_seg, redirect_off}, {8'd0, actual});
    end else if (actual == exp) begin
      chk(redirect_valid == 0 && cancel == 0, "R7 match no redirect",
          {30'd0, redirect_valid, cancel}, 32'd0);
    end else begin
      chk(redirect_valid == 1 && cancel == 1, "R8 mismatch flags",
          {30'd0, redirect_valid, cancel}, 32'd3);
      chk({redirect_seg, redirect_off} == actual, "R8 redirect addr",
          {8'd0, redirect_seg, redirect_off}, {8'd0, actual});
    end
    settle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; evt_valid = 0; act_valid = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    mcnt = 0;
    for (int i = 0; i < 6; i++) mstk[i] = '0;
  endtask

  task automatic t_reset_R1();
    do_call(8'h11, 16'h1111);
    do_reset();
    chk(cancel == 0 && redirect_valid == 0, "R1 outputs idle after reset",
        {30'd0, cancel, redirect_valid}, 0);
    do_ret(1'b1, 8'h00, 24'h123456, "R1 empty after reset");
  endtask

  task automatic t_lifo_R2();
    do_call(8'h01, 16'hA000);
    do_call(8'h02, 16'hB000);
    do_call(8'h03, 16'hC000);
    do_ret(1'b1, 8'h07, 24'h03C000, "R3 far return");
    do_ret(1'b0, 8'h07, 24'h07B000, "R4 near return uses cur_seg");
    do_ret(1'b1, 8'h09, 24'h01A000, "R2 LIFO order");
    do_ret(1'b1, 8'h09, 24'h00BEEF, "R11 drained");
  endtask

  task automatic t_trap_reti_R5_R6();
    do_call(8'h21, 16'h2121);
    do_simple(3'd2, "R5 trap no predict");
    do_simple(3'd5, "R6 reti no predict");
    do_simple(3'd5, "R6 reti again");
    do_ret(1'b1, 8'h00, 24'h212121, "R5 R6 entry intact");
    do_ret(1'b1, 8'h00, 24'h000042, "R5 nothing pushed by trap");
  endtask

  task automatic t_stale_R9();
    do_call(8'h31, 16'h0100);
    do_call(8'h32, 16'h0200);
    do_call(8'h33, 16'h0300);
    do_ret(1'b1, 8'h00, 24'h5A5A5A, "R8 altered return");
    do_ret(1'b1, 8'h00, 24'h6B6B6B, "R9 stale entry still used");
    do_ret(1'b0, 8'h44, 24'h440100, "R9 last entry intact");
  endtask

  task automatic t_overflow_R10();
    for (int i = 0; i < 7; i++) do_call(8'h40 + 8'(i), 16'h1000 + 16'(i));
    for (int i = 6; i >= 1; i--)
      do_ret(1'b1, 8'h00, {8'h40 + 8'(i), 16'h1000 + 16'(i)}, "R10 newest six");
    do_ret(1'b1, 8'h00, 24'h401000, "R10 oldest dropped");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; evt_valid = 0; evt_kind = 0; act_valid = 0;
    call_seg = 0; call_off = 0; cur_seg = 0; act_seg = 0; act_off = 0;
    last_pv = 0; last_pa = 0;
    do_reset();
    t_reset_R1();
    t_lifo_R2();
    t_trap_reti_R5_R6();
    do_reset();
    t_stale_R9();
    do_reset();
    t_overflow_R10();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule